// File: doc/BRIEF.md
# Wide Instruction Word Host Loader

This block lets a host with a 32-bit register bus load and inspect 128-bit sequencer instruction words. Every channel owns an instruction store of 32 steps, and each step is one 128-bit entry. A host address is split into a channel number, a fixed region tag, a step number and a quarter select. Four 32-bit accesses therefore cover one step. Each access writes or returns exactly one 32-bit slice of the entry.

Every channel also has a control register that holds a single hold flag. The host may change the instruction store only while that flag is set. Reads with the flag clear return zero. The block accepts only the addresses that belong to it, so other blocks can share the same bus. A consumer-side read port returns a whole 128-bit entry for any channel and step. This port is where the step contents become visible to the sequencer.

Bus timing follows a plain synchronous valid/ready strobe. The host raises valid and holds its address and data steady until ready answers, which happens for one cycle.

Top module: `wil_host_loader`

## Requirements
- R1: After synchronous reset, bus_ready is low, bus_rdata is zero, every hold flag is clear, and every entry of every channel reads as zero on the consumer port.
- R2: The address layout is bits 15:12 channel, bits 11:7 the tag 00010, bits 6:2 step (0 to 31) and bits 1:0 quarter. Quarter 0 maps to entry bits 31:0, quarter 1 to bits 63:32, quarter 2 to bits 95:64 and quarter 3 to bits 127:96.
- R3: A write to the instruction region while the channel's hold flag is set replaces only the addressed 32-bit quarter. The other three quarters of the entry keep their values.
- R4: A write to the instruction region while the channel's hold flag is clear is acknowledged and changes no stored bit.
- R5: A read of the instruction region returns the addressed quarter when the hold flag is set, and returns zero when the hold flag is clear.
- R6: An address whose bits 11:7 match neither the instruction tag nor the control offset, or whose channel number is not below NUM_CH, is never acknowledged. Such an access changes no state.
- R7: An accepted access raises bus_ready for exactly one cycle, in the cycle after valid was first sampled. bus_rdata is zero whenever bus_ready is low.
- R8: Each channel has a control register at local offset 0x000 (bits 11:0 all zero). Bit 0 of that register is the hold flag. A write sets the flag from wdata bit 0, and a read returns the flag in bit 0 with zeros elsewhere. hold_o bit n mirrors channel n's flag, and the flag changes only through such a write.
- R9: seq_word presents the entry selected by seq_chan and seq_step one clock edge after they are applied. It is zero for a channel number not below NUM_CH.
- R10: Channels are independent: a write to one channel never alters another channel's entries or hold flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Host request strobe, held until bus_ready |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 16 | Host address: channel, tag, step, quarter |
| bus_wdata | input | 32 | Host write data |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| hold_o | output | NUM_CH | Per-channel hold flags |
| seq_chan | input | 4 | Consumer read channel |
| seq_step | input | 5 | Consumer read step |
| seq_word | output | 128 | Registered 128-bit entry for the consumer |

## Verification
Every host result is due exactly one edge after valid is first sampled. That includes the acknowledge, the read data, the stored quarter and the new hold flag. The bench therefore drives on the falling edge and samples one time unit after each rising edge, and an access that gets no acknowledge within six edges counts as refused. The consumer word is due one edge after seq_chan and seq_step change. The bench checks that it still shows the old entry before that edge and the new entry after it. To show that an ignored write or an unmapped access had no effect, the bench reads the stored entries back through the consumer port or through a later host read with the hold flag set.

// File: rtl/wil_pkg.sv
package wil_pkg;
    localparam int BUS_W    = 32;
    localparam int WORD_W   = 128;
    localparam int QTRS     = WORD_W / BUS_W;
    localparam int QTR_W    = $clog2(QTRS);
    localparam int STEPS    = 32;
    localparam int STEP_W   = $clog2(STEPS);
    localparam int CHF_W    = 4;
    localparam int TAG_W    = 5;
    localparam int ADDR_W   = CHF_W + TAG_W + STEP_W + QTR_W;
    localparam int LOCAL_W  = ADDR_W - CHF_W;

    localparam logic [TAG_W-1:0]   INSTR_TAG  = 5'b00010;
    localparam logic [LOCAL_W-1:0] CTRL_LOCAL = '0;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_INSTR = 2'd1,
        RGN_CTRL  = 2'd2
    } wil_region_e;

    typedef struct packed {
        logic [CHF_W-1:0]  chan;
        wil_region_e       region;
        logic [STEP_W-1:0] step;
        logic [QTR_W-1:0]  qtr;
    } wil_dec_t;

    function automatic wil_dec_t wil_decode(input logic [ADDR_W-1:0] a);
        wil_dec_t d;
        d.chan = a[ADDR_W-1 -: CHF_W];
        d.step = a[QTR_W +: STEP_W];
        d.qtr  = a[QTR_W-1:0];
        if (a[QTR_W+STEP_W +: TAG_W] == INSTR_TAG)
            d.region = RGN_INSTR;
        else if (a[LOCAL_W-1:0] == CTRL_LOCAL)
            d.region = RGN_CTRL;
        else
            d.region = RGN_NONE;
        return d;
    endfunction
endpackage

// File: rtl/wil_addr_decode.sv
module wil_addr_decode
    import wil_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output wil_dec_t          dec,
    output logic              hit
);
    always_comb begin
        dec = wil_decode(addr);
        hit = (dec.region != RGN_NONE) && (int'(dec.chan) < NUM_CH);
    end
endmodule

// File: rtl/wil_chan_mem.sv
module wil_chan_mem
    import wil_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  wil_dec_t          dec,
    input  logic [BUS_W-1:0]  wdata,
    output logic              hold,
    output logic [BUS_W-1:0]  host_rdata,
    input  logic [STEP_W-1:0] seq_step,
    output logic [WORD_W-1:0] seq_entry
);
    logic [BUS_W-1:0] mem_q [STEPS][QTRS];
    logic             hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            for (int s = 0; s < STEPS; s++)
                for (int q = 0; q < QTRS; q++)
                    mem_q[s][q] <= '0;
        end else if (sel && wr) begin
            if (dec.region == RGN_CTRL)
                hold_q <= wdata[0];
            else if (dec.region == RGN_INSTR && hold_q)
                mem_q[dec.step][dec.qtr] <= wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (dec.region == RGN_CTRL)
            host_rdata[0] = hold_q;
        else if (dec.region == RGN_INSTR && hold_q)
            host_rdata = mem_q[dec.step][dec.qtr];
    end

    for (genvar q = 0; q < QTRS; q++) begin : g_slice
        assign seq_entry[q*BUS_W +: BUS_W] = mem_q[seq_step][q];
    end

    assign hold = hold_q;
endmodule

// File: rtl/wil_host_loader.sv
module wil_host_loader
    import wil_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic              bus_ready,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] hold_o,
    input  logic [CHF_W-1:0]  seq_chan,
    input  logic [STEP_W-1:0] seq_step,
    output logic [WORD_W-1:0] seq_word
);
    wil_dec_t         req_dec;
    logic             req_hit;
    logic             accept;
    logic             ready_q;
    logic [BUS_W-1:0] rdata_q;
    logic [BUS_W-1:0] rd_mux;
    logic [WORD_W-1:0] seq_mux;
    logic [WORD_W-1:0] seq_q;
    logic [BUS_W-1:0]  ch_rdata [NUM_CH];
    logic [WORD_W-1:0] ch_entry [NUM_CH];

    wil_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .dec  (req_dec),
        .hit  (req_hit)
    );

    assign accept = bus_valid && req_hit && !ready_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        wil_chan_mem u_mem (
            .clk        (clk),
            .rst        (rst),
            .sel        (accept && (int'(req_dec.chan) == c)),
            .wr         (bus_write),
            .dec        (req_dec),
            .wdata      (bus_wdata),
            .hold       (hold_o[c]),
            .host_rdata (ch_rdata[c]),
            .seq_step   (seq_step),
            .seq_entry  (ch_entry[c])
        );
    end

    always_comb begin
        rd_mux  = '0;
        seq_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(req_dec.chan) == c) rd_mux  = ch_rdata[c];
            if (int'(seq_chan) == c)     seq_mux = ch_entry[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
            seq_q   <= '0;
        end else begin
            ready_q <= accept;
            rdata_q <= (accept && !bus_write) ? rd_mux : '0;
            seq_q   <= seq_mux;
        end
    end

    assign bus_ready = ready_q;
    assign bus_rdata = rdata_q;
    assign seq_word  = seq_q;
endmodule

// File: rtl/wil_checker.sv
module wil_checker
    import wil_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              bus_ready,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [NUM_CH-1:0] hold_o,
    input logic              req_hit
);
    logic [CHF_W-1:0] a_chan;
    logic [CHF_W-1:0] last_chan;
    logic             a_instr, a_ctrl, cur_hold, past_hold;
    logic             ctrl_wr_take;

    assign a_chan  = bus_addr[ADDR_W-1 -: CHF_W];
    assign a_instr = (bus_addr[QTR_W+STEP_W +: TAG_W] == INSTR_TAG) && (int'(a_chan) < NUM_CH);
    assign a_ctrl  = !a_instr && (bus_addr[LOCAL_W-1:0] == CTRL_LOCAL) && (int'(a_chan) < NUM_CH);
    assign ctrl_wr_take = bus_valid && bus_write && a_ctrl && !bus_ready;

    always_ff @(posedge clk) last_chan <= a_chan;

    always_comb begin
        cur_hold  = 1'b0;
        past_hold = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(a_chan) == c)    cur_hold  = hold_o[c];
            if (int'(last_chan) == c) past_hold = hold_o[c];
        end
    end

    p_ready_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready);

    p_ready_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        bus_ready |-> $past(bus_valid));

    p_rdata_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |-> bus_rdata == '0);

    p_no_ack_unmapped_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !req_hit) |=> !bus_ready);

    p_read_gated_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && a_instr && !cur_hold && !bus_ready)
        |=> (bus_ready && bus_rdata == '0));

    p_hold_written_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr_take |=> past_hold == $past(bus_wdata[0]));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr_take |=> $stable(hold_o));
endmodule

bind wil_host_loader wil_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .hold_o    (hold_o),
    .req_hit   (req_hit)
);

// File: tb/sim_wil_host_loader.sv
`timescale 1ns/1ps
module sim_wil_host_loader;
    localparam int NCH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] hold_o;
    logic [3:0]    seq_chan = '0;
    logic [4:0]    seq_step = '0;
    logic [127:0]  seq_word;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    wil_host_loader #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .hold_o(hold_o), .seq_chan(seq_chan),
        .seq_step(seq_step), .seq_word(seq_word)
    );

    function automatic logic [15:0] ia(input int ch, input int st, input int q);
        return {ch[3:0], 5'b00010, st[4:0], q[1:0]};
    endfunction

    function automatic logic [15:0] ca(input int ch);
        return {ch[3:0], 12'h000};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [15:0] a, input logic [31:0] d,
                        output logic ack, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        ack = 1'b0; rd = '0;
        for (int i = 0; i < 6 && !ack; i++) begin
            @(posedge clk); #1;
            if (bus_ready) begin ack = 1'b1; rd = bus_rdata; end
        end
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr_ok(input logic [15:0] a, input logic [31:0] d, input string req);
        logic ack; logic [31:0] rd;
        xfer(1'b1, a, d, ack, rd);
        chk(ack, req, {127'b0, ack}, 128'd1);
    endtask

    task automatic rd_val(input logic [15:0] a, output logic [31:0] v, input string req);
        logic ack;
        xfer(1'b0, a, 32'h0, ack, v);
        chk(ack, req, {127'b0, ack}, 128'd1);
    endtask

    task automatic seq_get(input int ch, input int st, output logic [127:0] w);
        @(negedge clk);
        seq_chan = ch[3:0]; seq_step = st[4:0];
        @(posedge clk); #1;
        w = seq_word;
    endtask

    task automatic t_reset;
        logic [127:0] w;
        chk(bus_ready == 1'b0, "R1 ready", {127'b0, bus_ready}, 128'd0);
        chk(bus_rdata == '0, "R1 rdata", {96'b0, bus_rdata}, 128'd0);
        chk(hold_o == '0, "R1 hold", {124'b0, hold_o}, 128'd0);
        seq_get(2, 31, w);
        chk(w == '0, "R1 entry", w, 128'd0);
    endtask

    task automatic t_quarters;
        logic [127:0] w, e;
        logic [31:0] v;
        wr_ok(ca(1), 32'h1, "R8 set hold");
        for (int q = 0; q < 4; q++) wr_ok(ia(1, 7, q), 32'hA0A0_0000 + q, "R2 write");
        e = {32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000};
        seq_get(1, 7, w);
        chk(w == e, "R2 quarter order", w, e);
        wr_ok(ia(1, 7, 2), 32'h5555_AAAA, "R3 write");
        e[95:64] = 32'h5555_AAAA;
        seq_get(1, 7, w);
        chk(w == e, "R3 only one quarter", w, e);
        rd_val(ia(1, 7, 3), v, "R5 ack");
        chk(v == 32'hA0A0_0003, "R5 read set", {96'b0, v}, {96'b0, 32'hA0A0_0003});
        wr_ok(ia(1, 0, 0), 32'h0000_00F0, "R2 step0");
        wr_ok(ia(1, 31, 3), 32'hF000_0000, "R2 step31");
        seq_get(1, 0, w);
        chk(w == {96'b0, 32'h0000_00F0}, "R2 step 0", w, {96'b0, 32'h0000_00F0});
        seq_get(1, 31, w);
        chk(w == {32'hF000_0000, 96'b0}, "R2 step 31", w, {32'hF000_0000, 96'b0});
    endtask

    task automatic t_hold_gate;
        logic [31:0] v;
        wr_ok(ca(0), 32'h1, "R8 set");
        wr_ok(ia(0, 3, 1), 32'hCAFE_0001, "R4 setup");
        wr_ok(ca(0), 32'h0, "R8 clear");
        rd_val(ia(0, 3, 1), v, "R5 ack");
        chk(v == 32'h0, "R5 read clear gives zero", {96'b0, v}, 128'd0);
        wr_ok(ia(0, 3, 1), 32'hDEAD_BEEF, "R4 ack");
        wr_ok(ca(0), 32'h1, "R8 set");
        rd_val(ia(0, 3, 1), v, "R4 ack");
        chk(v == 32'hCAFE_0001, "R4 write ignored", {96'b0, v}, {96'b0, 32'hCAFE_0001});
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        wr_ok(ca(2), 32'hFFFF_FFFF, "R8 write");
        rd_val(ca(2), v, "R8 ack");
        chk(v == 32'h1, "R8 ctrl read", {96'b0, v}, 128'd1);
        chk(hold_o == 4'b0111, "R8 hold_o", {124'b0, hold_o}, {124'b0, 4'b0111});
        wr_ok(ca(2), 32'hFFFF_FFFE, "R8 clear");
        chk(hold_o == 4'b0011, "R8 hold_o clear", {124'b0, hold_o}, {124'b0, 4'b0011});
    endtask

    task automatic t_unmapped;
        logic ack; logic [31:0] rd; logic [127:0] w, e;
        xfer(1'b1, {4'd1, 5'b00011, 5'd7, 2'd0}, 32'h1234_5678, ack, rd);
        chk(!ack, "R6 bad tag no ack", {127'b0, ack}, 128'd0);
        xfer(1'b1, {4'd5, 5'b00010, 5'd7, 2'd0}, 32'h1234_5678, ack, rd);
        chk(!ack, "R6 bad channel no ack", {127'b0, ack}, 128'd0);
        xfer(1'b1, {4'd1, 12'h004}, 32'h0, ack, rd);
        chk(!ack, "R6 near ctrl no ack", {127'b0, ack}, 128'd0);
        chk(hold_o[1] == 1'b1, "R6 hold kept", {127'b0, hold_o[1]}, 128'd1);
        e = {32'hA0A0_0003, 32'h5555_AAAA, 32'hA0A0_0001, 32'hA0A0_0000};
        seq_get(1, 7, w);
        chk(w == e, "R6 entry kept", w, e);
    endtask

    task automatic t_channels;
        logic [31:0] v;
        wr_ok(ca(3), 32'h1, "R10 set");
        wr_ok(ia(3, 3, 1), 32'h3333_3333, "R10 write");
        rd_val(ia(0, 3, 1), v, "R10 ack");
        chk(v == 32'hCAFE_0001, "R10 other channel kept", {96'b0, v}, {96'b0, 32'hCAFE_0001});
        rd_val(ia(3, 3, 1), v, "R10 ack");
        chk(v == 32'h3333_3333, "R10 own channel", {96'b0, v}, {96'b0, 32'h3333_3333});
    endtask

    task automatic t_handshake;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ia(3, 3, 1);
        #1;
        chk(bus_ready == 1'b0, "R7 no early ready", {127'b0, bus_ready}, 128'd0);
        @(posedge clk); #1;
        chk(bus_ready == 1'b1, "R7 ready next cycle", {127'b0, bus_ready}, 128'd1);
        chk(bus_rdata == 32'h3333_3333, "R7 rdata with ready", {96'b0, bus_rdata}, {96'b0, 32'h3333_3333});
        @(negedge clk); bus_valid = 1'b0;
        @(posedge clk); #1;
        chk(bus_ready == 1'b0, "R7 one cycle pulse", {127'b0, bus_ready}, 128'd0);
        chk(bus_rdata == '0, "R7 rdata idle zero", {96'b0, bus_rdata}, 128'd0);
    endtask

    task automatic t_seq;
        logic [127:0] w;
        seq_get(3, 3, w);
        chk(w == {64'b0, 32'h3333_3333, 32'b0}, "R9 entry", w, {64'b0, 32'h3333_3333, 32'b0});
        @(negedge clk);
        seq_chan = 4'd1; seq_step = 5'd0;
        #1;
        chk(seq_word == {64'b0, 32'h3333_3333, 32'b0}, "R9 old before edge", seq_word, {64'b0, 32'h3333_3333, 32'b0});
        @(posedge clk); #1;
        chk(seq_word == {96'b0, 32'h0000_00F0}, "R9 new after edge", seq_word, {96'b0, 32'h0000_00F0});
        seq_get(9, 7, w);
        chk(w == '0, "R9 absent channel zero", w, 128'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset();
        t_quarters();
        t_hold_gate();
        t_ctrl();
        t_unmapped();
        t_channels();
        t_handshake();
        t_seq();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule